// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Reload Filter

This block is a 14-bit down-counting watchdog. It is clocked by the bus clock and advances only on a slow-tick enable pulse that comes from an independent low-rate oscillator. Software uses two word registers. The count register at offset 0 reads the live count and accepts reload writes. The control register at offset 4 holds the mode, the freeze enable and the reload-busy flag. Bit 13 of the count is a sign bit, so after zero the count wraps to 0x3FFF, then 0x3FFE, and so on.

The block has two escalation modes. In the default two-stage mode it raises a non-maskable interrupt level when the count reaches zero. It then keeps counting through a negative grace window and requests a system reset at 0x3FF0 (minus sixteen). In the sticky direct mode it requests a reset as soon as the count is zero or negative, and software freeze has no effect. A reload write is filtered: it is taken only when its upper eighteen bits are zero. It lands in the counter on the second slow tick after the write, and a busy flag is visible to software until then. A freeze request from outside and a debug-halt input can stop the count.

Top module: `wdog_top`

## Requirements
- R1: After reset the count reads 0x1FFF, the control register reads 0x6, and nmi_o and rst_req_o are low.
- R2: Each tick_i pulse while not frozen decrements the 14-bit count by one, wrapping from 0 to 0x3FFF. A read at address 0 returns the count in bits 13:0 with zeros above.
- R3: A write to address 0 is accepted only when wdata_i[31:14] is zero, and it stages wdata_i[13:0] as the reload value. Any other write to address 0 changes nothing.
- R4: After an accepted reload write, control bit 3 (busy) reads 1. The first following tick still decrements the old count. The second following tick loads the staged value and clears busy. Reload writes made while busy is 1 are ignored.
- R5: In mode 0, nmi_o rises one clock after the count becomes 0. It stays high until a reload lands or a watchdog reset occurs.
- R6: In mode 0, a watchdog reset happens the clock after the count becomes 0x3FF0, and not at 0x3FF1.
- R7: In mode 1 (control bit 0), a watchdog reset happens the clock after the count is zero or negative.
- R8: A watchdog reset drives rst_req_o high for exactly one clock. In that same clock it sets the count to 0x1FFF, clears nmi_o and busy, and returns the control register to 0x6.
- R9: Writing 1 to control bit 0 sets mode 1. Writing 0 to it does not clear it; only rst_ni or a watchdog reset clears it.
- R10: With control bit 2 set and mode 0, a freeze_set_i pulse stops the count and a freeze_clr_i pulse resumes it. freeze_set_i has no effect when bit 2 is 0 or mode is 1.
- R11: While dbg_halt_i is high the count does not change on ticks, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low power-on or software reset |
| tick_i | input | 1 | Slow-clock enable pulse, one bus clock wide |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 3 | Byte address: 0 = count, 4 = control |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| freeze_set_i | input | 1 | Pulse that requests the count to stop |
| freeze_clr_i | input | 1 | Pulse that resumes the count |
| dbg_halt_i | input | 1 | Processor halted in debug; stops the count |
| nmi_o | output | 1 | Non-maskable interrupt level |
| rst_req_o | output | 1 | One-clock system reset request |

## Verification
A slow tick can land a staged reload in the same cycle that the counter would otherwise decrement. The counter must then take the reload value and not the decremented one. The bench provokes this on every table vector by issuing two ticks after a write and reading the count. An accepted write must show the exact written value minus the later ticks, and a rejected one must show the old value minus every tick. A further directed case writes a second reload during the busy window and checks that the first value is the one that lands.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned CNT_W      = 14;
    localparam int unsigned DATA_W     = 32;
    localparam logic [CNT_W-1:0] CNT_INIT  = 14'h1FFF;
    localparam logic [CNT_W-1:0] CNT_LAST  = 14'h3FF0;
    localparam logic [3:0]       CTRL_INIT = 4'h6;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned SYNC_TICKS = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wd_rst_i,
    output logic              mode_o,
    output logic              frz_en_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o
);
    localparam int unsigned TW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(SYNC_TICKS - 1);

    typedef struct packed {
        logic             mode;
        logic             frz_en;
        logic             busy;
        logic [TW-1:0]    tcnt;
        logic [CNT_W-1:0] pend;
    } regs_st_t;

    regs_st_t s_d, s_q;
    logic sel_val, sel_ctl, wr_ok, land;
    logic unused_wbits;

    assign unused_wbits = ^{wdata_i[31:3], wdata_i[1]};
    assign sel_val = (addr_i == ADDR_W'(0));
    assign sel_ctl = (addr_i == ADDR_W'(4));
    assign wr_ok   = req_i && we_i && sel_val && !s_q.busy
                     && (wdata_i[DATA_W-1:CNT_W] == '0);
    assign land    = s_q.busy && tick_i && (s_q.tcnt == T_LAST);

    always_comb begin
        s_d = s_q;
        if (wd_rst_i) begin
            s_d.mode   = CTRL_INIT[0];
            s_d.frz_en = CTRL_INIT[2];
            s_d.busy   = 1'b0;
            s_d.tcnt   = '0;
        end else begin
            if (req_i && we_i && sel_ctl) begin
                s_d.mode   = s_q.mode | wdata_i[0];
                s_d.frz_en = wdata_i[2];
            end
            if (land) begin
                s_d.busy = 1'b0;
                s_d.tcnt = '0;
            end else if (s_q.busy && tick_i) begin
                s_d.tcnt = s_q.tcnt + 1'b1;
            end
            if (wr_ok) begin
                s_d.busy = 1'b1;
                s_d.tcnt = '0;
                s_d.pend = wdata_i[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.mode   <= CTRL_INIT[0];
            s_q.frz_en <= CTRL_INIT[2];
            s_q.busy   <= 1'b0;
            s_q.tcnt   <= '0;
            s_q.pend   <= CNT_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_val) rdata_o[CNT_W-1:0] = cnt_i;
        else if (sel_ctl) rdata_o[3:0] = {s_q.busy, s_q.frz_en, CTRL_INIT[1], s_q.mode};
    end

    assign mode_o     = s_q.mode;
    assign frz_en_o   = s_q.frz_en;
    assign load_o     = land;
    assign load_val_o = s_q.pend;

    // R9
    mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.mode && !wd_rst_i) |=> s_q.mode);
    // R4
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && !tick_i && !wd_rst_i) |=> (s_q.busy && $stable(s_q.pend)));
    // R3
    filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.busy && req_i && we_i && sel_val && (wdata_i[DATA_W-1:CNT_W] != '0))
        |=> !s_q.busy);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             mode_i,
    input  logic             frz_en_i,
    input  logic             freeze_set_i,
    input  logic             freeze_clr_i,
    input  logic             dbg_halt_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             nmi_o,
    output logic             rst_req_o,
    output logic             wd_rst_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             nmi;
        logic             rst_req;
        logic             frz;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic fire, frozen;

    assign fire   = mode_i ? ((s_q.cnt == '0) || s_q.cnt[CNT_W-1])
                           : (s_q.cnt == CNT_LAST);
    assign frozen = dbg_halt_i || (s_q.frz && frz_en_i && !mode_i);

    always_comb begin
        s_d         = s_q;
        s_d.rst_req = 1'b0;
        if (freeze_clr_i) s_d.frz = 1'b0;
        else if (freeze_set_i && frz_en_i && !mode_i) s_d.frz = 1'b1;
        if (fire) begin
            s_d.cnt     = CNT_INIT;
            s_d.nmi     = 1'b0;
            s_d.rst_req = 1'b1;
            s_d.frz     = 1'b0;
        end else if (load_i) begin
            s_d.cnt = load_val_i;
            s_d.nmi = 1'b0;
        end else begin
            if (tick_i && !frozen) s_d.cnt = s_q.cnt - 1'b1;
            if (!mode_i && (s_q.cnt == '0)) s_d.nmi = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt     <= CNT_INIT;
            s_q.nmi     <= 1'b0;
            s_q.rst_req <= 1'b0;
            s_q.frz     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o     = s_q.cnt;
    assign nmi_o     = s_q.nmi;
    assign rst_req_o = s_q.rst_req;
    assign wd_rst_o  = fire;

    // R8
    rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.rst_req |=> !s_q.rst_req);
    // R8
    rst_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.rst_req |-> (s_q.cnt == CNT_INIT && !s_q.nmi));
    // R2
    step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !frozen && !load_i && !fire) |=> (s_q.cnt == $past(s_q.cnt) - 14'd1));
    // R11
    halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_halt_i && !load_i && !fire) |=> $stable(s_q.cnt));
    // R5
    nmi_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.nmi) |-> ($past(s_q.cnt) == '0));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned SYNC_TICKS = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              freeze_set_i,
    input  logic              freeze_clr_i,
    input  logic              dbg_halt_i,
    output logic              nmi_o,
    output logic              rst_req_o
);
    logic [CNT_W-1:0] cnt, load_val;
    logic mode, frz_en, load, wd_rst;

    wdog_regs #(.ADDR_W(ADDR_W), .SYNC_TICKS(SYNC_TICKS)) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
        .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_i(cnt),
        .wd_rst_i(wd_rst), .mode_o(mode), .frz_en_o(frz_en),
        .load_o(load), .load_val_o(load_val)
    );

    wdog_counter cnt_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
        .mode_i(mode), .frz_en_i(frz_en),
        .freeze_set_i(freeze_set_i), .freeze_clr_i(freeze_clr_i),
        .dbg_halt_i(dbg_halt_i), .load_i(load), .load_val_i(load_val),
        .cnt_o(cnt), .nmi_o(nmi_o), .rst_req_o(rst_req_o), .wd_rst_o(wd_rst)
    );
endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, req = 1'b0, we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic fset = 1'b0, fclr = 1'b0, dbg = 1'b0;
    logic nmi, rreq;
    int total = 0, bad = 0, rst_seen = 0;
    logic [13:0] c0;

    always #4 clk = ~clk;

    wdog_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .freeze_set_i(fset), .freeze_clr_i(fclr), .dbg_halt_i(dbg),
        .nmi_o(nmi), .rst_req_o(rreq)
    );

    always @(negedge clk) if (rst_n && rreq) rst_seen++;

    // vector: {wdata[31:0], extra ticks[7:0], expected count[13:0]}
    localparam logic [53:0] VEC [6] = '{
        {32'h0000_0050, 8'd5, 14'h004B},
        {32'h0004_0050, 8'd5, 14'h00F9},
        {32'h8000_0010, 8'd0, 14'h00FE},
        {32'h0000_0003, 8'd5, 14'h3FFE},
        {32'h0000_2005, 8'd1, 14'h2004},
        {32'h0000_1FFF, 8'd2, 14'h1FFD}
    };

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); req = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_set();
        @(negedge clk); fset = 1'b1; @(negedge clk); fset = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); fclr = 1'b1; @(negedge clk); fclr = 1'b0;
    endtask

    task automatic reload(input logic [13:0] v);
        wr(3'd0, {18'd0, v});
        ticks(2);
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, r); chk("R1 count", r, 32'h1FFF);
        rd(3'd4, r); chk("R1 ctrl", r, 32'h6);
        chk("R1 nmi", {31'd0, nmi}, 32'd0);
        chk("R1 rst_req", {31'd0, rreq}, 32'd0);

        // R3 R4 table walk: landing tick coincides with decrement
        for (int k = 0; k < 6; k++) begin
            reload(14'h0100);
            wr(3'd0, VEC[k][53:22]);
            ticks(2);
            ticks(int'(VEC[k][21:14]));
            rd(3'd0, r);
            chk("R3 table count", r, {18'd0, VEC[k][13:0]});
        end

        // R2 wrap through zero
        reload(14'h0001);
        ticks(2);
        rd(3'd0, r); chk("R2 wrap", r, 32'h3FFF);

        // R4 busy window and write during busy
        reload(14'h0080);
        wr(3'd0, 32'h40);
        rd(3'd4, r); chk("R4 busy set", {31'd0, r[3]}, 32'd1);
        wr(3'd0, 32'h50);
        ticks(1);
        rd(3'd0, r); chk("R4 first tick decrements", r, 32'h7F);
        rd(3'd4, r); chk("R4 still busy", {31'd0, r[3]}, 32'd1);
        ticks(1);
        rd(3'd0, r); chk("R4 landed value", r, 32'h40);
        rd(3'd4, r); chk("R4 busy clear", {31'd0, r[3]}, 32'd0);

        // R5 R6 two-stage escalation
        reload(14'h0003);
        ticks(2);
        @(negedge clk);
        chk("R5 nmi low at 1", {31'd0, nmi}, 32'd0);
        ticks(1);
        @(negedge clk);
        chk("R5 nmi at zero", {31'd0, nmi}, 32'd1);
        ticks(15);
        repeat (2) @(negedge clk);
        chk("R6 no reset at 3FF1", rst_seen, 0);
        chk("R5 nmi held", {31'd0, nmi}, 32'd1);
        ticks(1);
        repeat (2) @(negedge clk);
        chk("R6 reset at 3FF0", rst_seen, 1);
        rd(3'd0, r); chk("R8 count reload", r, 32'h1FFF);
        chk("R8 nmi cleared", {31'd0, nmi}, 32'd0);

        // R9 sticky mode, R10 freeze ignored in mode 1
        wr(3'd4, 32'h5);
        rd(3'd4, r); chk("R9 mode set", {31'd0, r[0]}, 32'd1);
        wr(3'd4, 32'h4);
        rd(3'd4, r); chk("R9 mode sticky", {31'd0, r[0]}, 32'd1);
        pulse_set();
        rd(3'd0, r); c0 = r[13:0];
        ticks(1);
        rd(3'd0, r); chk("R10 no freeze in mode 1", r, {18'd0, c0 - 14'd1});
        pulse_clr();

        // R7 direct reset in mode 1
        reload(14'h0002);
        ticks(1);
        chk("R7 no reset at 1", rst_seen, 1);
        ticks(1);
        repeat (2) @(negedge clk);
        chk("R7 reset at zero", rst_seen, 2);
        rd(3'd4, r); chk("R8 ctrl restored", r, 32'h6);
        rd(3'd0, r); chk("R8 count after mode1 reset", r, 32'h1FFF);

        // R10 freeze in mode 0
        rd(3'd0, r); c0 = r[13:0];
        pulse_set();
        ticks(3);
        rd(3'd0, r); chk("R10 frozen", r, {18'd0, c0});
        pulse_clr();
        ticks(1);
        rd(3'd0, r); chk("R10 resumed", r, {18'd0, c0 - 14'd1});
        wr(3'd4, 32'h0);
        pulse_set();
        ticks(1);
        rd(3'd0, r); chk("R10 freeze disabled", r, {18'd0, c0 - 14'd2});
        pulse_clr();

        // R11 debug halt
        @(negedge clk); dbg = 1'b1;
        ticks(3);
        rd(3'd0, r); chk("R11 halted", r, {18'd0, c0 - 14'd2});
        @(negedge clk); dbg = 1'b0;
        ticks(1);
        rd(3'd0, r); chk("R11 released", r, {18'd0, c0 - 14'd3});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule